// File: doc/BRIEF.md
# Programmable External Bus Strobe Sequencer

This block times one access to an external card-style IO or common-memory space. It drives two active-low strobes: an address strobe and a data strobe. Each access has three phases, and each phase length is programmed in bus clock cycles. The setup phase runs from the fall of the address strobe to the fall of the data strobe. The active phase is the time the data strobe stays low. The hold phase runs from the rise of the data strobe to the rise of the address strobe.

A single timing register holds the three phase fields and a bit that selects the IO space width. Every field stores the wanted cycle count minus one. The register clears to zero on reset, so an unprogrammed access spends one cycle in each phase.

A request input starts a read or a write. When the request is accepted, the phase values, the width bit and the direction are captured. A busy output covers the access, and a done pulse marks its end.

Top module: `strobe_seq`

## Requirements
- R1: After reset, `as_n` and `ds_n` are high, and `busy`, `done` and `wide` are low. The timing register is zero, so an access started without any configuration write spends exactly 1 cycle in each of setup, active and hold.
- R2: A request sampled high while idle is accepted. On the next cycle `as_n` goes low with `ds_n` still high. `as_n` then stays low with `ds_n` high for (setup field + 1) cycles, where the setup field is `cfg_wdata[FIELD_W-1:0]`.
- R3: `ds_n` then stays low for (active field + 1) cycles, where the active field is `cfg_wdata[2*FIELD_W-1:FIELD_W]`. `as_n` stays low throughout.
- R4: After `ds_n` returns high, `as_n` stays low for (hold field + 1) cycles before it returns high. The hold field is `cfg_wdata[3*FIELD_W-1:2*FIELD_W]`.
- R5: `busy` is high from the cycle after acceptance through the last hold cycle. `done` is high for exactly one cycle, the cycle in which `as_n` has returned high.
- R6: A request raised while `busy` is high is ignored. It neither changes the current phase lengths nor starts a further access after `done`.
- R7: A timing register write during an access leaves that access unchanged. The written values govern the next access.
- R8: The width bit `cfg_wdata[3*FIELD_W]` selects the IO space width: 0 selects the 8-bit space and 1 selects the 16-bit space. The captured width is shown on `wide`, and the captured `rnw` on `acc_rnw`, unchanged for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Timing register write enable |
| cfg_wdata | input | 3*FIELD_W+1 | Width bit, hold, active and setup fields |
| req | input | 1 | Access request, sampled while idle |
| rnw | input | 1 | Direction of the requested access (1 = read) |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| wide | output | 1 | Captured IO width (1 = 16-bit) |
| acc_rnw | output | 1 | Captured direction of the current access |

## Verification
The bench builds the sequencer with `FIELD_W` = 6. An all-ones field, which gives the longest phase of 64 cycles, can then be reached in every phase by directed and random accesses alike. With the same width, the counter reload at each phase boundary is exercised against both zero and maximum values within a short run. Random field values and directions fill the space between these extremes. Directed accesses place a request and a register write inside a running access.

// File: rtl/strobe_seq.sv
module strobe_seq #(
  parameter int FIELD_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [3*FIELD_W:0]     cfg_wdata,
  input  logic                   req,
  input  logic                   rnw,
  output logic                   as_n,
  output logic                   ds_n,
  output logic                   busy,
  output logic                   done,
  output logic                   wide,
  output logic                   acc_rnw
);

  localparam int CFG_W   = 3*FIELD_W + 1;
  localparam int SET_LO  = 0;
  localparam int ACT_LO  = FIELD_W;
  localparam int HLD_LO  = 2*FIELD_W;
  localparam int WID_BIT = 3*FIELD_W;

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ACTIVE, S_HOLD} phase_t;

  phase_t              phase;
  logic [CFG_W-1:0]    cfg_q;
  logic [FIELD_W-1:0]  cnt;
  logic [FIELD_W-1:0]  act_q;
  logic [FIELD_W-1:0]  hold_q;
  logic                start;
  logic                last;

  assign start = (phase == S_IDLE) && req;
  assign last  = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= S_IDLE;
      cnt     <= '0;
      act_q   <= '0;
      hold_q  <= '0;
      wide    <= 1'b0;
      acc_rnw <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        S_IDLE: if (start) begin
          phase   <= S_SETUP;
          cnt     <= cfg_q[SET_LO +: FIELD_W];
          act_q   <= cfg_q[ACT_LO +: FIELD_W];
          hold_q  <= cfg_q[HLD_LO +: FIELD_W];
          wide    <= cfg_q[WID_BIT];
          acc_rnw <= rnw;
        end
        S_SETUP: if (last) begin
          phase <= S_ACTIVE;
          cnt   <= act_q;
        end else cnt <= cnt - 1'b1;
        S_ACTIVE: if (last) begin
          phase <= S_HOLD;
          cnt   <= hold_q;
        end else cnt <= cnt - 1'b1;
        S_HOLD: if (last) begin
          phase <= S_IDLE;
          done  <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: phase <= S_IDLE;
      endcase
    end
  end

  assign as_n = (phase == S_IDLE);
  assign ds_n = (phase != S_ACTIVE);
  assign busy = (phase != S_IDLE);

  // R3
  ds_inside_as_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_n |-> !as_n);

  // R2
  setup_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ds_n) |-> $past(!as_n));

  // R4
  hold_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(as_n) |-> $past(ds_n));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (as_n && !busy && $past(busy)) ##1 !done);

  // R6
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!as_n && ds_n));

  // R8
  wide_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(wide) && $stable(acc_rnw)));

endmodule

// File: tb/tb_strobe_seq.sv
module tb_strobe_seq;
  localparam int FW = 6;
  localparam int CW = 3*FW + 1;
  localparam int FMAX = (1 << FW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, cfg_we, req, rnw;
  logic [CW-1:0] cfg_wdata;
  logic          as_n, ds_n, busy, done, wide, acc_rnw;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  strobe_seq #(.FIELD_W(FW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req(req), .rnw(rnw), .as_n(as_n), .ds_n(ds_n), .busy(busy),
    .done(done), .wide(wide), .acc_rnw(acc_rnw));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] pack(input int s, input int a, input int h, input bit w);
    logic [CW-1:0] v;
    v = '0;
    v[FW-1:0]      = s[FW-1:0];
    v[2*FW-1:FW]   = a[FW-1:0];
    v[3*FW-1:2*FW] = h[FW-1:0];
    v[3*FW]        = w;
    return v;
  endfunction

  function automatic int plen(input int field);
    return field + 1;
  endfunction

  task automatic write_cfg(input logic [CW-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_access(input int s, input int a, input int h, input bit w, input bit r,
                           input bit poke, input bit midcfg, input logic [CW-1:0] newcfg);
    int cs = 0, ca = 0, ch = 0, g = 0;
    bit side_ok = 1;
    @(negedge clk);
    req = 1'b1;
    rnw = r;
    @(negedge clk);
    req = 1'b0;
    rnw = ~r;
    chk(!as_n && ds_n && busy, "R2 accept", {as_n, ds_n, busy}, 3'b011);
    while (!as_n && ds_n && g < 5000) begin
      cs++; g++;
      if (wide !== w || acc_rnw !== r) side_ok = 0;
      @(negedge clk);
    end
    while (!ds_n && g < 5000) begin
      if (ca == 0 && poke) req = 1'b1; else req = 1'b0;
      if (ca == 0 && midcfg) begin cfg_we = 1'b1; cfg_wdata = newcfg; end
      else cfg_we = 1'b0;
      if (as_n || !busy) side_ok = 0;
      if (wide !== w || acc_rnw !== r) side_ok = 0;
      ca++; g++;
      @(negedge clk);
    end
    req = 1'b0;
    cfg_we = 1'b0;
    while (!as_n && g < 5000) begin
      if (!ds_n || !busy || done) side_ok = 0;
      if (wide !== w || acc_rnw !== r) side_ok = 0;
      ch++; g++;
      @(negedge clk);
    end
    chk(cs == plen(s), "R2 setup cycles", cs, plen(s));
    chk(ca == plen(a), "R3 active cycles", ca, plen(a));
    chk(ch == plen(h), "R4 hold cycles", ch, plen(h));
    chk(side_ok, "R8 wide/acc_rnw stable, R5 busy", side_ok, 1);
    chk(done && !busy && as_n, "R5 done at end", {done, busy, as_n}, 3'b101);
    @(negedge clk);
    chk(!done && as_n && !busy, "R5 done one cycle / R6 no restart", {done, as_n, busy}, 3'b010);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; req = 1'b0; rnw = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(as_n && ds_n && !busy && !done && !wide, "R1 reset outputs",
        {as_n, ds_n, busy, done, wide}, 5'b11000);
    // R1 default one-cycle phases
    do_access(0, 0, 0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    // R2 R3 R4 maximum fields, R8 wide space
    write_cfg(pack(FMAX, FMAX, FMAX, 1'b1));
    do_access(FMAX, FMAX, FMAX, 1'b1, 1'b0, 1'b0, 1'b0, '0);
    // R6 request during access
    write_cfg(pack(3, 5, 2, 1'b0));
    do_access(3, 5, 2, 1'b0, 1'b1, 1'b1, 1'b0, '0);
    // R7 write during access applies to next one
    do_access(3, 5, 2, 1'b0, 1'b0, 1'b0, 1'b1, pack(7, 0, 9, 1'b1));
    do_access(7, 0, 9, 1'b1, 1'b1, 1'b0, 1'b0, '0);
    // R6 R7 combined, single-cycle active
    write_cfg(pack(0, 0, 4, 1'b1));
    do_access(0, 0, 4, 1'b1, 1'b0, 1'b1, 1'b1, pack(2, 1, 0, 1'b0));
    do_access(2, 1, 0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
    // random accesses, R2 R3 R4 R8
    for (int i = 0; i < 40; i++) begin
      int s, a, h;
      bit w, r;
      s = $urandom_range(0, FMAX);
      a = $urandom_range(0, FMAX);
      h = $urandom_range(0, FMAX);
      w = $urandom_range(0, 1);
      r = $urandom_range(0, 1);
      write_cfg(pack(s, a, h, w));
      do_access(s, a, h, w, r, 1'b0, 1'b0, '0);
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule